// File: doc/BRIEF.md
# Reorder buffer commit controller

This block holds a circular window of in-flight instructions and retires them in program order from its oldest slot. Up to a fixed number of slots leave the window per clock. Each slot records an instruction's sequence number and a few flags: completed, faulted, serialising, released and killed. The execute stage marks a slot complete by its slot index. It can also ask for a squash of everything younger than a given slot, either after a wrong branch guess (which also steers fetch to a new address) or after a load/store ordering hazard.

A serialising instruction waits until it is the oldest candidate in the cycle and no stores are waiting to write back. It is then released once for execution and retires after it completes. An oldest slot that completed with a fault does not retire. It raises a trap request, and a fixed number of cycles later a trap squash kills every slot in the window. Killed slots then drain out without architectural effect. A pending interrupt is taken through the same trap path in a cycle in which nothing retires. In each cycle the commit decision is made before the allocation decision, so a slot freed by retirement can be refilled in the same clock.

Top module: `rob_commit_ctrl`

## Requirements
- R1: After reset the window is empty: allocReady is 1, allocIdx is 0, and retireMask, drainMask, squashValid, trapReq and releaseValid are all 0.
- R2: Retirement takes completed, unfaulted, unkilled slots in order from the oldest. It takes at most COMMIT_W slots per cycle and stops at the first slot that cannot leave. Bit k of retireMask and field k of retireSeq (bits k*SEQ_W upward) describe the k-th oldest slot, and the set bits are always contiguous from bit 0.
- R3: In any cycle in which squashValid is 1, retireMask and drainMask are 0 and allocReady is 0.
- R4: A squash request with sqIsBranch=1 gives, in the same cycle, squashValid=1, squashSeq=sqSeq, redirectValid=1 and redirectPc=sqNextPc. Every slot younger than sqIdx is removed, so the next allocation goes to slot sqIdx+1.
- R5: A squash request with sqIsBranch=0 gives squashValid=1 and squashSeq=sqSeq with redirectValid=0, and it rolls back the window in the same way as R4.
- R6: A killed slot leaves through drainMask and never through retireMask, even if a completion mark reaches it after it was killed. Drained slots count against the per-cycle limit.
- R7: A serialising slot makes progress only when it is the oldest slot and storesPending is 0. If it is not yet complete, releaseValid pulses for one cycle with releaseIdx set to its slot, and it is not released again. It retires normally once it completes.
- R8: An oldest slot that completed with a fault raises trapReq for one cycle and does not retire. Nothing retires until the trap squash, which comes TRAP_DELAY cycles after trapReq with trapSquash=1, squashValid=1 and squashSeq equal to the faulting sequence number minus one. After the trap squash every slot then in the window drains.
- R9: When irqPending is 1 and no trap is in progress, trapReq is raised in that cycle with nothing retired, and the same delayed trap squash follows.
- R10: With DEPTH slots occupied, allocReady is 0 unless a slot leaves in the same cycle, in which case allocReady is 1 and the new instruction takes the freed position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | New instruction offered for the youngest position |
| allocNonSpec | input | 1 | Offered instruction is serialising |
| allocSeq | input | SEQ_W | Sequence number of the offered instruction |
| allocReady | output | 1 | Offered instruction is accepted this cycle |
| allocIdx | output | IDX_W | Slot the offered instruction will occupy |
| cmplValid | input | 1 | Completion mark from execute |
| cmplIdx | input | IDX_W | Slot being marked complete |
| cmplFault | input | 1 | Completed instruction faulted |
| storesPending | input | 1 | Stores still waiting to write back |
| irqPending | input | 1 | Interrupt waiting to be taken |
| sqValid | input | 1 | Squash request from execute |
| sqIsBranch | input | 1 | 1 for a branch misguess, 0 for an ordering hazard |
| sqIdx | input | IDX_W | Slot of the youngest instruction that survives |
| sqSeq | input | SEQ_W | Sequence number of that surviving instruction |
| sqNextPc | input | PC_W | Fetch target after a branch misguess |
| retireMask | output | COMMIT_W | Slots retired this cycle, oldest in bit 0 |
| drainMask | output | COMMIT_W | Killed slots removed this cycle |
| retireSeq | output | COMMIT_W*SEQ_W | Sequence numbers of the oldest slots |
| releaseValid | output | 1 | Serialising oldest slot released for execution |
| releaseIdx | output | IDX_W | Slot being released |
| squashValid | output | 1 | Squash broadcast |
| squashSeq | output | SEQ_W | Youngest sequence number that survives the squash |
| redirectValid | output | 1 | Fetch redirect |
| redirectPc | output | PC_W | Fetch redirect target |
| trapReq | output | 1 | Trap raised by a fault or an interrupt |
| trapSquash | output | 1 | Delayed trap squash taking effect |

## Verification
The assertions check several properties on every cycle. Retire and drain masks stay contiguous, and nothing leaves or enters in a squash cycle. A redirect never appears without a squash, and no release happens while stores are pending. A trap request lasts one cycle and is followed by a cycle with no retirement, and occupancy never exceeds the window size. Other behaviours can only be shown through the bench's scenarios: retirement order and sequence numbers, the slot position after a rollback, the exact trap-squash cycle and its sequence number, that a serialising slot is released only once, that killed slots drain rather than retire, and reuse of a freed slot in a full window.

// File: rtl/robc_pkg.sv
package robc_pkg;
  typedef struct packed {
    logic killed;
    logic done;
    logic serial;
    logic mayIssue;
    logic faulted;
  } slotFlags_t;

  typedef struct packed {
    logic release1;
    logic rollback;
    logic killAll;
  } ctlStrobe_t;
endpackage

// File: rtl/robc_store.sv
module robc_store
  import robc_pkg::*;
#(
  parameter int unsigned DEPTH    = 8,
  parameter int unsigned COMMIT_W = 2,
  parameter int unsigned SEQ_W    = 8,
  localparam int unsigned IDX_W   = $clog2(DEPTH),
  localparam int unsigned PTR_W   = IDX_W + 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            allocFire,
  input  logic                            allocNonSpec,
  input  logic [SEQ_W-1:0]                allocSeq,
  input  logic                            cmplValid,
  input  logic [IDX_W-1:0]                cmplIdx,
  input  logic                            cmplFault,
  input  ctlStrobe_t                      strb,
  input  logic [PTR_W-1:0]                popCnt,
  input  logic [PTR_W-1:0]                rollTail,
  output logic [PTR_W-1:0]                headPtr,
  output logic [PTR_W-1:0]                tailPtr,
  output slotFlags_t [COMMIT_W-1:0]       winFlags,
  output logic [COMMIT_W-1:0][SEQ_W-1:0]  winSeq
);
  slotFlags_t             flags  [DEPTH];
  logic [SEQ_W-1:0]       seqMem [DEPTH];
  logic [IDX_W-1:0]       headIdx, tailIdx;

  assign headIdx = headPtr[IDX_W-1:0];
  assign tailIdx = tailPtr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
      for (int i = 0; i < DEPTH; i++) flags[i] <= '0;
    end else begin
      headPtr <= headPtr + popCnt;
      if (strb.rollback)  tailPtr <= rollTail;
      else if (allocFire) tailPtr <= tailPtr + PTR_W'(1);
      for (int i = 0; i < DEPTH; i++) begin
        if (cmplValid && cmplIdx == IDX_W'(i) && !flags[i].killed) begin
          flags[i].done    <= 1'b1;
          flags[i].faulted <= cmplFault;
        end
        if (strb.killAll) flags[i].killed <= 1'b1;
        if (strb.release1 && headIdx == IDX_W'(i)) flags[i].mayIssue <= 1'b0;
        if (allocFire && tailIdx == IDX_W'(i)) begin
          flags[i].killed   <= 1'b0;
          flags[i].done     <= 1'b0;
          flags[i].serial   <= allocNonSpec;
          flags[i].mayIssue <= 1'b1;
          flags[i].faulted  <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (allocFire) seqMem[tailIdx] <= allocSeq;
  end

  always_comb begin
    for (int k = 0; k < COMMIT_W; k++) begin
      winFlags[k] = flags[headIdx + IDX_W'(k)];
      winSeq[k]   = seqMem[headIdx + IDX_W'(k)];
    end
  end

  // R10
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tailPtr - headPtr) <= PTR_W'(DEPTH));
endmodule

// File: rtl/robc_ctl.sv
module robc_ctl
  import robc_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned COMMIT_W   = 2,
  parameter int unsigned SEQ_W      = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned TRAP_DELAY = 2,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned PTR_W     = IDX_W + 1,
  localparam int unsigned CNT_W     = $clog2(TRAP_DELAY + 1)
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [PTR_W-1:0]                headPtr,
  input  logic [PTR_W-1:0]                tailPtr,
  input  slotFlags_t [COMMIT_W-1:0]       winFlags,
  input  logic [COMMIT_W-1:0][SEQ_W-1:0]  winSeq,
  input  logic                            storesPending,
  input  logic                            irqPending,
  input  logic                            sqValid,
  input  logic                            sqIsBranch,
  input  logic [IDX_W-1:0]                sqIdx,
  input  logic [SEQ_W-1:0]                sqSeq,
  input  logic [PC_W-1:0]                 sqNextPc,
  output ctlStrobe_t                      strb,
  output logic [PTR_W-1:0]                popCnt,
  output logic [PTR_W-1:0]                rollTail,
  output logic                            allocReady,
  output logic [COMMIT_W-1:0]             retireMask,
  output logic [COMMIT_W-1:0]             drainMask,
  output logic [COMMIT_W*SEQ_W-1:0]       retireSeq,
  output logic                            releaseValid,
  output logic [IDX_W-1:0]                releaseIdx,
  output logic                            squashValid,
  output logic [SEQ_W-1:0]                squashSeq,
  output logic                            redirectValid,
  output logic [PC_W-1:0]                 redirectPc,
  output logic                            trapReq,
  output logic                            trapSquash
);
  logic [CNT_W-1:0] trapCnt;
  logic [SEQ_W-1:0] trapSeq;
  logic [PTR_W-1:0] occ;
  logic             trapFire, extSq, halt, stop, relFlag, faultHit, irqTake;
  logic [COMMIT_W-1:0] leftMask;

  assign occ      = tailPtr - headPtr;
  assign trapFire = (trapCnt == CNT_W'(1));
  assign extSq    = sqValid && !trapFire;
  assign halt     = sqValid || (trapCnt != '0);
  assign irqTake  = irqPending && !halt;

  // Oldest-first scan over the commit window
  always_comb begin
    stop       = halt || irqPending;
    popCnt     = '0;
    retireMask = '0;
    drainMask  = '0;
    relFlag    = 1'b0;
    faultHit   = 1'b0;
    for (int k = 0; k < COMMIT_W; k++) begin
      if (!stop) begin
        if (PTR_W'(k) >= occ) begin
          stop = 1'b1;
        end else if (winFlags[k].killed) begin
          drainMask[k] = 1'b1;
          popCnt       = popCnt + PTR_W'(1);
        end else if (winFlags[k].serial && (k != 0 || storesPending)) begin
          stop = 1'b1;
        end else if (!winFlags[k].done) begin
          relFlag = winFlags[k].serial && winFlags[k].mayIssue;
          stop    = 1'b1;
        end else if (winFlags[k].faulted) begin
          faultHit = (k == 0);
          stop     = 1'b1;
        end else begin
          retireMask[k] = 1'b1;
          popCnt        = popCnt + PTR_W'(1);
        end
      end
    end
  end

  always_comb begin
    for (int k = 0; k < COMMIT_W; k++) retireSeq[k*SEQ_W +: SEQ_W] = winSeq[k];
  end

  assign trapReq = faultHit || irqTake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapCnt <= '0;
      trapSeq <= '0;
    end else if (trapReq) begin
      trapCnt <= CNT_W'(TRAP_DELAY);
      trapSeq <= winSeq[0] - SEQ_W'(1);
    end else if (trapCnt != '0) begin
      trapCnt <= trapCnt - CNT_W'(1);
    end
  end

  assign squashValid   = trapFire || extSq;
  assign squashSeq     = trapFire ? trapSeq : sqSeq;
  assign redirectValid = extSq && sqIsBranch;
  assign redirectPc    = sqNextPc;
  assign trapSquash    = trapFire;
  assign releaseValid  = relFlag;
  assign releaseIdx    = headPtr[IDX_W-1:0];
  assign rollTail      = headPtr + {1'b0, sqIdx - headPtr[IDX_W-1:0]} + PTR_W'(1);
  assign allocReady    = !squashValid && ((occ - popCnt) != PTR_W'(DEPTH));

  assign strb.release1 = relFlag;
  assign strb.rollback = extSq;
  assign strb.killAll  = trapFire;

  assign leftMask = retireMask | drainMask;

  // R2
  leave_contig_chk: assert property (@(posedge clk) disable iff (!rstN)
    (leftMask & (leftMask + COMMIT_W'(1))) == '0);
  // R3
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> (leftMask == '0 && !allocReady));
  // R4
  redirect_squash_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> squashValid);
  // R7
  release_no_stores_chk: assert property (@(posedge clk) disable iff (!rstN)
    releaseValid |-> !storesPending);
  // R8
  trap_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> (!trapReq && retireMask == '0));
endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl
  import robc_pkg::*;
#(
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned COMMIT_W   = 2,
  parameter int unsigned SEQ_W      = 8,
  parameter int unsigned PC_W       = 32,
  parameter int unsigned TRAP_DELAY = 2,
  localparam int unsigned IDX_W     = $clog2(DEPTH),
  localparam int unsigned PTR_W     = IDX_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      allocValid,
  input  logic                      allocNonSpec,
  input  logic [SEQ_W-1:0]          allocSeq,
  output logic                      allocReady,
  output logic [IDX_W-1:0]          allocIdx,
  input  logic                      cmplValid,
  input  logic [IDX_W-1:0]          cmplIdx,
  input  logic                      cmplFault,
  input  logic                      storesPending,
  input  logic                      irqPending,
  input  logic                      sqValid,
  input  logic                      sqIsBranch,
  input  logic [IDX_W-1:0]          sqIdx,
  input  logic [SEQ_W-1:0]          sqSeq,
  input  logic [PC_W-1:0]           sqNextPc,
  output logic [COMMIT_W-1:0]       retireMask,
  output logic [COMMIT_W-1:0]       drainMask,
  output logic [COMMIT_W*SEQ_W-1:0] retireSeq,
  output logic                      releaseValid,
  output logic [IDX_W-1:0]          releaseIdx,
  output logic                      squashValid,
  output logic [SEQ_W-1:0]          squashSeq,
  output logic                      redirectValid,
  output logic [PC_W-1:0]           redirectPc,
  output logic                      trapReq,
  output logic                      trapSquash
);
  ctlStrobe_t                     strb;
  logic [PTR_W-1:0]               popCnt, rollTail, headPtr, tailPtr;
  slotFlags_t [COMMIT_W-1:0]      winFlags;
  logic [COMMIT_W-1:0][SEQ_W-1:0] winSeq;
  logic                           allocFire;

  assign allocFire = allocValid && allocReady;
  assign allocIdx  = tailPtr[IDX_W-1:0];

  robc_store #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W)) uStore (
    .clk(clk), .rstN(rstN), .allocFire(allocFire), .allocNonSpec(allocNonSpec),
    .allocSeq(allocSeq), .cmplValid(cmplValid), .cmplIdx(cmplIdx),
    .cmplFault(cmplFault), .strb(strb), .popCnt(popCnt), .rollTail(rollTail),
    .headPtr(headPtr), .tailPtr(tailPtr), .winFlags(winFlags), .winSeq(winSeq)
  );

  robc_ctl #(.DEPTH(DEPTH), .COMMIT_W(COMMIT_W), .SEQ_W(SEQ_W), .PC_W(PC_W),
             .TRAP_DELAY(TRAP_DELAY)) uCtl (
    .clk(clk), .rstN(rstN), .headPtr(headPtr), .tailPtr(tailPtr),
    .winFlags(winFlags), .winSeq(winSeq), .storesPending(storesPending),
    .irqPending(irqPending), .sqValid(sqValid), .sqIsBranch(sqIsBranch),
    .sqIdx(sqIdx), .sqSeq(sqSeq), .sqNextPc(sqNextPc), .strb(strb),
    .popCnt(popCnt), .rollTail(rollTail), .allocReady(allocReady),
    .retireMask(retireMask), .drainMask(drainMask), .retireSeq(retireSeq),
    .releaseValid(releaseValid), .releaseIdx(releaseIdx),
    .squashValid(squashValid), .squashSeq(squashSeq),
    .redirectValid(redirectValid), .redirectPc(redirectPc),
    .trapReq(trapReq), .trapSquash(trapSquash)
  );
endmodule

// File: tb/tb_rob_commit_ctrl.sv
module tb_rob_commit_ctrl;
  logic clk = 1'b0;
  logic rstN;
  logic allocValid, allocNonSpec, allocReady;
  logic [7:0] allocSeq;
  logic [2:0] allocIdx;
  logic cmplValid, cmplFault, storesPending, irqPending, sqValid, sqIsBranch;
  logic [2:0] cmplIdx, sqIdx, releaseIdx;
  logic [7:0] sqSeq, squashSeq;
  logic [15:0] sqNextPc, redirectPc;
  logic [1:0] retireMask, drainMask;
  logic [15:0] retireSeq;
  logic releaseValid, squashValid, redirectValid, trapReq, trapSquash;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rob_commit_ctrl #(.DEPTH(8), .COMMIT_W(2), .SEQ_W(8), .PC_W(16), .TRAP_DELAY(2)) dut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocNonSpec(allocNonSpec),
    .allocSeq(allocSeq), .allocReady(allocReady), .allocIdx(allocIdx),
    .cmplValid(cmplValid), .cmplIdx(cmplIdx), .cmplFault(cmplFault),
    .storesPending(storesPending), .irqPending(irqPending), .sqValid(sqValid),
    .sqIsBranch(sqIsBranch), .sqIdx(sqIdx), .sqSeq(sqSeq), .sqNextPc(sqNextPc),
    .retireMask(retireMask), .drainMask(drainMask), .retireSeq(retireSeq),
    .releaseValid(releaseValid), .releaseIdx(releaseIdx), .squashValid(squashValid),
    .squashSeq(squashSeq), .redirectValid(redirectValid), .redirectPc(redirectPc),
    .trapReq(trapReq), .trapSquash(trapSquash)
  );

  typedef struct packed {
    logic       aV;
    logic [7:0] aSeq;
    logic       cV;
    logic [2:0] cIdx;
    logic [1:0] expR;
    logic [7:0] s0;
    logic [7:0] s1;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 8'd10, 1'b0, 3'd0, 2'b00, 8'd0,  8'd0},
    '{1'b1, 8'd11, 1'b0, 3'd0, 2'b00, 8'd0,  8'd0},
    '{1'b1, 8'd12, 1'b1, 3'd1, 2'b00, 8'd0,  8'd0},
    '{1'b1, 8'd13, 1'b1, 3'd0, 2'b00, 8'd0,  8'd0},
    '{1'b0, 8'd0,  1'b1, 3'd2, 2'b11, 8'd10, 8'd11},
    '{1'b0, 8'd0,  1'b1, 3'd3, 2'b01, 8'd12, 8'd0},
    '{1'b0, 8'd0,  1'b0, 3'd0, 2'b01, 8'd13, 8'd0},
    '{1'b0, 8'd0,  1'b0, 3'd0, 2'b00, 8'd0,  8'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    allocValid = 1'b0; allocNonSpec = 1'b0; allocSeq = '0;
    cmplValid = 1'b0; cmplIdx = '0; cmplFault = 1'b0;
    storesPending = 1'b0; irqPending = 1'b0;
    sqValid = 1'b0; sqIsBranch = 1'b0; sqIdx = '0; sqSeq = '0; sqNextPc = '0;
  endtask

  task automatic nextCyc();
    @(negedge clk);
    idle();
  endtask

  task automatic doAlloc(input logic [7:0] s, input logic ns);
    allocValid = 1'b1; allocSeq = s; allocNonSpec = ns;
  endtask

  task automatic doCmpl(input logic [2:0] idx, input logic f);
    cmplValid = 1'b1; cmplIdx = idx; cmplFault = f;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1 reset state
    check("R1 allocReady", 32'(allocReady), 32'd1);
    check("R1 allocIdx", 32'(allocIdx), 32'd0);
    check("R1 masks", 32'({retireMask, drainMask}), 32'd0);
    check("R1 broadcasts", 32'({squashValid, trapReq, releaseValid}), 32'd0);

    // R2 vector table: in-order retirement under the bandwidth limit
    for (int i = 0; i < 8; i++) begin
      nextCyc();
      if (VEC[i].aV) doAlloc(VEC[i].aSeq, 1'b0);
      if (VEC[i].cV) doCmpl(VEC[i].cIdx, 1'b0);
      #2;
      check("R2 retireMask", 32'(retireMask), 32'(VEC[i].expR));
      if (VEC[i].expR[0]) check("R2 retireSeq0", 32'(retireSeq[7:0]), 32'(VEC[i].s0));
      if (VEC[i].expR[1]) check("R2 retireSeq1", 32'(retireSeq[15:8]), 32'(VEC[i].s1));
    end

    // R4 / R3 branch misguess squash with rollback
    nextCyc(); doAlloc(8'd20, 1'b0);
    nextCyc(); doAlloc(8'd21, 1'b0);
    nextCyc(); doAlloc(8'd22, 1'b0);
    nextCyc(); doAlloc(8'd23, 1'b0); doCmpl(3'd4, 1'b0);
    nextCyc();
    sqValid = 1'b1; sqIsBranch = 1'b1; sqIdx = 3'd5; sqSeq = 8'd21; sqNextPc = 16'h1234;
    #2;
    check("R3 no retire in squash", 32'(retireMask), 32'd0);
    check("R3 no alloc in squash", 32'(allocReady), 32'd0);
    check("R4 squashValid", 32'(squashValid), 32'd1);
    check("R4 squashSeq", 32'(squashSeq), 32'd21);
    check("R4 redirect", 32'({redirectValid, redirectPc}), 32'h11234);
    nextCyc(); #2;
    check("R4 head retires after squash", 32'(retireMask), 32'd1);
    check("R4 head seq", 32'(retireSeq[7:0]), 32'd20);
    check("R4 rollback allocIdx", 32'(allocIdx), 32'd6);

    // R5 ordering-hazard squash
    nextCyc();
    sqValid = 1'b1; sqIsBranch = 1'b0; sqIdx = 3'd5; sqSeq = 8'd21;
    #2;
    check("R5 squashValid", 32'(squashValid), 32'd1);
    check("R5 squashSeq", 32'(squashSeq), 32'd21);
    check("R5 no redirect", 32'(redirectValid), 32'd0);
    nextCyc(); doCmpl(3'd5, 1'b0);
    nextCyc(); #2;
    check("R5 survivor retires", 32'({retireMask, retireSeq[7:0]}), 32'h115);
    check("R5 allocIdx", 32'(allocIdx), 32'd6);

    // R7 serialising instruction
    nextCyc(); doAlloc(8'd30, 1'b0);
    nextCyc(); doAlloc(8'd31, 1'b1); doCmpl(3'd6, 1'b0);
    nextCyc(); storesPending = 1'b1; #2;
    check("R7 serial not first stalls", 32'(retireMask), 32'd1);
    check("R7 no release", 32'(releaseValid), 32'd0);
    nextCyc(); storesPending = 1'b1; #2;
    check("R7 stores pending stalls", 32'({releaseValid, retireMask}), 32'd0);
    nextCyc(); #2;
    check("R7 release", 32'({releaseValid, releaseIdx}), 32'hF);
    check("R7 release no retire", 32'(retireMask), 32'd0);
    nextCyc(); #2;
    check("R7 no second release", 32'({releaseValid, retireMask}), 32'd0);
    nextCyc(); doCmpl(3'd7, 1'b0); #2;
    check("R7 waits for completion", 32'(retireMask), 32'd0);
    nextCyc(); #2;
    check("R7 retires after completion", 32'({retireMask, retireSeq[7:0]}), 32'h11F);

    // R8 fault trap, R6 drain of killed slots
    nextCyc(); doAlloc(8'd40, 1'b0);
    nextCyc(); doAlloc(8'd41, 1'b0);
    nextCyc(); doAlloc(8'd42, 1'b0); doCmpl(3'd0, 1'b1);
    nextCyc(); doCmpl(3'd1, 1'b0); #2;
    check("R8 trapReq", 32'(trapReq), 32'd1);
    check("R8 faulting head not retired", 32'(retireMask), 32'd0);
    nextCyc(); #2;
    check("R8 trap one cycle", 32'({trapReq, squashValid, retireMask}), 32'd0);
    nextCyc(); #2;
    check("R8 trapSquash", 32'({trapSquash, squashValid}), 32'd3);
    check("R8 trap squashSeq", 32'(squashSeq), 32'd39);
    check("R8 no retire at trap squash", 32'(retireMask), 32'd0);
    nextCyc(); doCmpl(3'd2, 1'b0); #2;
    check("R6 drain two", 32'({retireMask, drainMask}), 32'd3);
    nextCyc(); #2;
    check("R6 late completion still drains", 32'({retireMask, drainMask}), 32'd1);
    nextCyc(); #2;
    check("R6 window empty", 32'({retireMask, drainMask}), 32'd0);

    // R9 interrupt
    nextCyc(); doAlloc(8'd50, 1'b0);
    nextCyc(); doCmpl(3'd3, 1'b0);
    nextCyc(); irqPending = 1'b1; #2;
    check("R9 trapReq", 32'(trapReq), 32'd1);
    check("R9 nothing retires", 32'(retireMask), 32'd0);
    nextCyc(); #2;
    check("R9 waiting", 32'({trapReq, trapSquash, retireMask}), 32'd0);
    nextCyc(); #2;
    check("R9 trapSquash", 32'({trapSquash, squashSeq}), 32'h131);
    nextCyc(); #2;
    check("R9 drain", 32'({retireMask, drainMask}), 32'd1);

    // R10 full window with wrap
    for (int i = 0; i < 8; i++) begin
      nextCyc(); doAlloc(8'(60 + i), 1'b0);
    end
    nextCyc(); doCmpl(3'd4, 1'b0); #2;
    check("R10 full refuses", 32'(allocReady), 32'd0);
    nextCyc(); doAlloc(8'd68, 1'b0); #2;
    check("R10 retire while full", 32'({retireMask, retireSeq[7:0]}), 32'h13C);
    check("R10 freed slot accepted", 32'({allocReady, allocIdx}), 32'hC);
    nextCyc(); #2;
    check("R10 full again", 32'(allocReady), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule